// File: doc/BRIEF.md
# SD Data-Line Timeout Monitor

This block watches a data transfer on an SD card bus and reports when the card stays silent for too long. While a transfer is active it counts SD clock cycles. It starts the count again whenever a block goes across the data lines. If the count reaches the programmed limit with no restart, the block raises a sticky timeout flag. A controller polls that flag, or takes it as an interrupt.

The limit is programmed as an exponent N in a 4-bit field. The window is 2^(N+OFFSET) SD clock cycles, and OFFSET is 13 by default. A small field therefore covers a very wide range of windows. Software writes the field as part of a 32-bit control word. It clears the flag by writing a 32-bit status word in which each 1 bit clears the flag it covers.

Two masks qualify the flag:
- A status enable decides whether an expiry records the flag at all.
- A signal enable decides whether a recorded flag drives the interrupt line.

A data-line reset request throws away the count and the flag.

The controller is a three-state machine:
- `ST_IDLE`: no transfer, and the count is held at zero.
- `ST_COUNT`: the window is running.
- `ST_EXPIRED`: the window has run out, and the machine waits for the next block or for the transfer to end.

The transitions are:
- IDLE→COUNT when the transfer becomes active.
- COUNT→COUNT with the count restarted on each data event.
- COUNT→EXPIRED when the last cycle of the window passes.
- COUNT→IDLE and EXPIRED→IDLE when the transfer ends.
- EXPIRED→COUNT on a data event.
- Any state→IDLE on a data-line reset.

Top module: `sd_data_timeout`

## Requirements
- R1: With the transfer held active and no data event, the flag rises on the clock edge 2^(N+OFFSET) edges after the first edge that samples the transfer active. It is still low one edge earlier.
- R2: A control write loads the exponent from bits 19:16 of the write data and ignores all other bits. A value of 15 is stored as 14. The stored value can be read on `tmo_exp`.
- R3: After reset the stored exponent is 14, and the flag and the interrupt are low.
- R4: A data event sampled while the transfer is active starts a full window again. The edge that samples the event counts as the start of that window.
- R5: While the transfer is inactive the count stays at zero and no flag is raised, however long that lasts. When the transfer becomes active again, a full window starts.
- R6: If the status enable is low when the window expires, the flag is not recorded.
- R7: The interrupt output equals the flag ANDed with the signal enable. The flag can be read with the signal enable low.
- R8: Once set, the flag stays set after the transfer ends. It stays set until a status write has bit 20 set. A write of all ones clears it.
- R9: A status write with bit 20 clear leaves the flag unchanged.
- R10: A data-line reset clears the flag on the edge that samples it. The next window then starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; exponent in bits 19:16 |
| sts_wr | input | 1 | Status word write strobe (write one to clear) |
| sts_wdata | input | 32 | Status write data; bit 20 clears the timeout flag |
| xfer_active | input | 1 | A data transfer is in progress |
| data_event | input | 1 | A block was sent or received; starts the window again |
| line_rst | input | 1 | Data-line reset request |
| stat_en | input | 1 | Status enable for the timeout flag |
| sig_en | input | 1 | Interrupt signal enable for the timeout flag |
| tmo_exp | output | 4 | Stored timeout exponent |
| tmo_flag | output | 1 | Sticky timeout status flag |
| tmo_irq | output | 1 | Timeout interrupt request |

## Verification
A wrong count or a missed restart shows at the ports only as a timing error: the flag edge arrives earlier or later than 2^(N+OFFSET) edges after the window start. The bench therefore checks the flag on the cycle just before the exact expiry edge and on the expiry edge itself. A wrong state can also show a spurious flag while the transfer is idle, or a flag that disappears without a clear. These errors appear one cycle after the event that caused them, so the checks follow each stimulus immediately. A run with a small OFFSET makes every window short enough to check to the exact edge.

// File: rtl/sdto_pkg.sv
package sdto_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_COUNT    = 2'd1,
        ST_EXPIRED  = 2'd2
    } sdto_state_e;

endpackage

// File: rtl/sdto_cfg.sv
module sdto_cfg #(
    parameter int WORD_W  = 32,
    parameter int EXP_W   = 4,
    parameter int EXP_LSB = 16,
    parameter int EXP_MAX = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [EXP_W-1:0] ctl_field,
    output logic [EXP_W-1:0] exp_q
);
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_MAX);

    logic [EXP_W-1:0] exp_clamped;

    always_comb begin
        exp_clamped = (ctl_field > EXP_TOP) ? EXP_TOP : ctl_field;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= EXP_TOP;
        end else if (ctl_wr) begin
            exp_q <= exp_clamped;
        end
    end

    AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_field <= EXP_TOP) |=> exp_q == $past(ctl_field)); // R2

endmodule

// File: rtl/sdto_fsm.sv
module sdto_fsm
    import sdto_pkg::*;
#(
    parameter int EXP_W   = 4,
    parameter int OFFSET  = 13,
    parameter int EXP_MAX = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_q,
    input  logic             xfer_active,
    input  logic             data_event,
    input  logic             line_rst,
    output logic             expire_pulse
);
    localparam int CNT_W = EXP_MAX + OFFSET + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    sdto_state_e      state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (ONE << (CNT_W'(exp_q) + CNT_W'(OFFSET))) - ONE;
    end

    always_comb begin
        state_nxt = state_q;
        if (line_rst) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (xfer_active) state_nxt = ST_COUNT;
                end
                ST_COUNT: begin
                    if (!xfer_active)           state_nxt = ST_IDLE;
                    else if (data_event)        state_nxt = ST_COUNT;
                    else if (cnt_q >= last_cnt) state_nxt = ST_EXPIRED;
                end
                ST_EXPIRED: begin
                    if (!xfer_active)    state_nxt = ST_IDLE;
                    else if (data_event) state_nxt = ST_COUNT;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == ST_COUNT && state_nxt == ST_COUNT && !data_event) begin
            cnt_q <= cnt_q + ONE;
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        expire_pulse = (state_q == ST_COUNT) && (state_nxt == ST_EXPIRED);
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> cnt_q == '0); // R5
    AST_EVENT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && data_event) |=> cnt_q == '0); // R4
    AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst |=> (state_q == ST_IDLE && cnt_q == '0)); // R10

endmodule

// File: rtl/sdto_flag.sv
module sdto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_pulse,
    input  logic stat_en,
    input  logic sig_en,
    input  logic clr_hit,
    input  logic line_rst,
    output logic flag_q,
    output logic irq
);
    logic set_hit;

    always_comb begin
        set_hit = expire_pulse && stat_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (line_rst) begin
            flag_q <= 1'b0;
        end else if (set_hit) begin
            flag_q <= 1'b1;
        end else if (clr_hit) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        irq = flag_q && sig_en;
    end

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !line_rst && !clr_hit) |=> flag_q); // R8
    AST_SET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(stat_en)); // R6
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        line_rst |=> !flag_q); // R10

endmodule

// File: rtl/sd_data_timeout.sv
module sd_data_timeout #(
    parameter int WORD_W   = 32,
    parameter int EXP_W    = 4,
    parameter int EXP_LSB  = 16,
    parameter int EXP_MAX  = 14,
    parameter int OFFSET   = 13,
    parameter int FLAG_BIT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [WORD_W-1:0] ctl_wdata,
    input  logic              sts_wr,
    input  logic [WORD_W-1:0] sts_wdata,
    input  logic              xfer_active,
    input  logic              data_event,
    input  logic              line_rst,
    input  logic              stat_en,
    input  logic              sig_en,
    output logic [EXP_W-1:0]  tmo_exp,
    output logic              tmo_flag,
    output logic              tmo_irq
);
    localparam logic [WORD_W-1:0] EXP_MASK  = WORD_W'(((1 << EXP_W) - 1) << EXP_LSB);
    localparam logic [WORD_W-1:0] FLAG_MASK = WORD_W'(1) << FLAG_BIT;

    logic             expire_pulse;
    logic             clr_hit;
    logic [EXP_W-1:0] ctl_field;
    logic             unused_bits;

    assign ctl_field   = ctl_wdata[EXP_LSB +: EXP_W];
    assign clr_hit     = sts_wr && sts_wdata[FLAG_BIT];
    assign unused_bits = ^{ctl_wdata & ~EXP_MASK, sts_wdata & ~FLAG_MASK};

    sdto_cfg #(
        .WORD_W (WORD_W),
        .EXP_W  (EXP_W),
        .EXP_LSB(EXP_LSB),
        .EXP_MAX(EXP_MAX)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_field(ctl_field),
        .exp_q    (tmo_exp)
    );

    sdto_fsm #(
        .EXP_W  (EXP_W),
        .OFFSET (OFFSET),
        .EXP_MAX(EXP_MAX)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .exp_q       (tmo_exp),
        .xfer_active (xfer_active),
        .data_event  (data_event),
        .line_rst    (line_rst),
        .expire_pulse(expire_pulse)
    );

    sdto_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire_pulse(expire_pulse),
        .stat_en     (stat_en),
        .sig_en      (sig_en),
        .clr_hit     (clr_hit),
        .line_rst    (line_rst),
        .flag_q      (tmo_flag),
        .irq         (tmo_irq)
    );

endmodule

// File: tb/sd_data_timeout_tb_top.sv
`timescale 1ns/1ps
module sd_data_timeout_tb_top;
    localparam int OFF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic        xfer_active = 1'b0;
    logic        data_event = 1'b0;
    logic        line_rst = 1'b0;
    logic        stat_en = 1'b1;
    logic        sig_en = 1'b1;
    logic [3:0]  tmo_exp;
    logic        tmo_flag;
    logic        tmo_irq;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sd_data_timeout #(.OFFSET(OFF)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .xfer_active(xfer_active),
        .data_event(data_event), .line_rst(line_rst), .stat_en(stat_en),
        .sig_en(sig_en), .tmo_exp(tmo_exp), .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_exp(input logic [31:0] word);
        ctl_wr = 1'b1; ctl_wdata = word;
        tick();
        ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic sts_write(input logic [31:0] word);
        sts_wr = 1'b1; sts_wdata = word;
        tick();
        sts_wr = 1'b0; sts_wdata = '0;
    endtask

    task automatic end_and_clear();
        xfer_active = 1'b0;
        tick();
        sts_write(32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        check("R3 exp", int'(tmo_exp), 14);
        check("R3 flag", int'(tmo_flag), 0);
        check("R3 irq", int'(tmo_irq), 0);
    endtask

    task automatic t_field();
        set_exp(32'hFFFF_FFFF);
        check("R2 clamp 15", int'(tmo_exp), 14);
        set_exp(32'h000A_FFFF);
        check("R2 field 10", int'(tmo_exp), 10);
        set_exp(32'hFFF3_FFFF);
        check("R2 field 3", int'(tmo_exp), 3);
    endtask

    task automatic t_expiry(input int n);
        int lim = 1 << (n + OFF);
        set_exp(32'(n) << 16);
        xfer_active = 1'b1;
        tick();
        tick(lim - 1);
        check("R1 before limit", int'(tmo_flag), 0);
        tick();
        check("R1 at limit", int'(tmo_flag), 1);
        xfer_active = 1'b0;
        tick(3);
        check("R8 sticky after end", int'(tmo_flag), 1);
        sts_write(32'hFFFF_FFFF);
        check("R8 all ones clears", int'(tmo_flag), 0);
    endtask

    task automatic t_restart();
        set_exp(32'h0001_0000);
        xfer_active = 1'b1;
        tick(6);
        data_event = 1'b1;
        tick();
        data_event = 1'b0;
        tick(7);
        check("R4 no early expiry", int'(tmo_flag), 0);
        tick();
        check("R4 expiry after restart", int'(tmo_flag), 1);
        end_and_clear();
    endtask

    task automatic t_inactive();
        set_exp(32'h0);
        xfer_active = 1'b0;
        tick(40);
        check("R5 idle no flag", int'(tmo_flag), 0);
        xfer_active = 1'b1;
        tick(3);
        xfer_active = 1'b0;
        tick();
        xfer_active = 1'b1;
        tick(4);
        check("R5 reactivation restarts", int'(tmo_flag), 0);
        tick();
        check("R5 expiry after reactivation", int'(tmo_flag), 1);
        end_and_clear();
    endtask

    task automatic t_masks();
        set_exp(32'h0);
        stat_en = 1'b0;
        xfer_active = 1'b1;
        tick(10);
        check("R6 status disabled", int'(tmo_flag), 0);
        xfer_active = 1'b0;
        tick();
        stat_en = 1'b1;
        sig_en = 1'b0;
        xfer_active = 1'b1;
        tick(5);
        check("R7 flag polled", int'(tmo_flag), 1);
        check("R7 irq masked", int'(tmo_irq), 0);
        sig_en = 1'b1;
        #1;
        check("R7 irq enabled", int'(tmo_irq), 1);
        xfer_active = 1'b0;
        tick();
        sts_write(32'hFFEF_FFFF);
        check("R9 bit20 clear keeps flag", int'(tmo_flag), 1);
        sts_write(32'h0010_0000);
        check("R8 bit20 clears", int'(tmo_flag), 0);
        check("R7 irq follows clear", int'(tmo_irq), 0);
    endtask

    task automatic t_line_rst();
        set_exp(32'h0001_0000);
        xfer_active = 1'b1;
        tick(9);
        check("R10 pre flag", int'(tmo_flag), 1);
        line_rst = 1'b1;
        tick();
        line_rst = 1'b0;
        check("R10 flag cleared", int'(tmo_flag), 0);
        tick(8);
        check("R10 window restarted", int'(tmo_flag), 0);
        tick();
        check("R10 expiry after reset", int'(tmo_flag), 1);
        end_and_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_field();
        t_expiry(0);
        t_expiry(3);
        t_restart();
        t_inactive();
        t_masks();
        t_line_rst();
        set_exp(32'hFFFF_FFFF);
        t_expiry(14);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule